// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two eight-line priority interrupt controllers into one sixteen-line unit. The upper controller (the primary) owns request lines 0 to 7 and drives the single interrupt output. The lower controller (the secondary) owns lines 8 to 15. Its interrupt output does not leave the block. It feeds primary line 2, which is always treated as level-sensitive. The external input on line 2 is never looked at. Each controller keeps a request register, an in-service register and a priority rotation offset. Its mask, vector base and end-of-interrupt modes come in from a command interface block as plain configuration inputs.

A processor-side agent raises `ack_req` for one cycle while `int_out` is high. On the next cycle `ack_valid` pulses and `ack_vector` carries the vector. If the primary's winning line is the cascade line, the secondary is resolved and acknowledged in the same cycle, and the vector comes from the secondary's base. Each controller also has a trigger-mode register, written and read through a small port. Per-controller write masks keep certain lines edge-sensitive and fix the cascade line as level-sensitive.

Top module: `irq_cascade_pair`

## Requirements
- R1: After reset, `int_out` and `ack_valid` are low. Both trigger-mode registers read back 0x00, even though the primary internally holds its line 2 as level-sensitive.
- R2: Trigger-mode writes store only the bits of mask 0xF8 (primary, `tm_sel`=0) or 0xDE (secondary, `tm_sel`=1). The primary's bit 2 is always forced to level. A read returns the stored value ANDed with the same mask. A 1 bit means level-sensitive.
- R3: A rising edge on a request input sets its request bit, and a falling edge clears it. Either edge on external input 2 (`irq_in[2]`) has no effect on the output.
- R4: Just after reset the rotation offset is zero, so the lowest-numbered unmasked requested line wins. An accepted acknowledge gives `ack_valid` one cycle later, with `ack_vector` = {vector base (5 bits), line (3 bits)}.
- R5: Acknowledging an edge-sensitive line clears its request bit. A level-sensitive line keeps its request bit and is requested again once its in-service bit is cleared.
- R6: Without auto end-of-interrupt, an acknowledged line becomes in-service. It then blocks lines of equal or lower priority while a higher-priority request still drives `int_out`. An end-of-interrupt naming a controller (`eoi_sel`) and a line clears that in-service bit.
- R7: A request on the secondary raises primary line 2 one cycle later. Acknowledging it returns the secondary's vector base plus its line (the global line minus 8) and puts both controllers' lines in service.
- R8: With auto end-of-interrupt, an acknowledge sets no in-service bit. When rotation on auto end-of-interrupt is also enabled, the rotation offset becomes (line + 1) mod 8, so the acknowledged line drops to the lowest priority.
- R9: An `ack_req` while `int_out` is low is ignored: `ack_valid` stays low.
- R10: A line whose mask bit is set cannot assert `int_out`. Its request bit is kept, and it raises `int_out` once unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Request inputs; bits 7:0 primary, bits 15:8 secondary |
| m_imr | input | 8 | Primary line mask (1 = masked) |
| s_imr | input | 8 | Secondary line mask (1 = masked) |
| m_vbase | input | 5 | Primary vector base (upper five vector bits) |
| s_vbase | input | 5 | Secondary vector base (upper five vector bits) |
| m_aeoi | input | 1 | Primary auto end-of-interrupt enable |
| s_aeoi | input | 1 | Secondary auto end-of-interrupt enable |
| m_rot_aeoi | input | 1 | Primary rotate on auto end-of-interrupt |
| s_rot_aeoi | input | 1 | Secondary rotate on auto end-of-interrupt |
| eoi_req | input | 1 | Specific end-of-interrupt strobe |
| eoi_sel | input | 1 | End-of-interrupt target: 0 primary, 1 secondary |
| eoi_line | input | 3 | Line whose in-service bit is cleared |
| tm_wr | input | 1 | Trigger-mode register write strobe |
| tm_sel | input | 1 | Trigger-mode register select: 0 primary, 1 secondary |
| tm_wdata | input | 8 | Trigger-mode write data |
| tm_rdata | output | 8 | Trigger-mode read data (masked) |
| int_out | output | 1 | Interrupt output from the primary |
| ack_req | input | 1 | Single-cycle acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid, one cycle after an accepted request |
| ack_vector | output | 8 | Registered interrupt vector |

## Verification
The assertions check several properties on every cycle. The acknowledge handshake never answers when the output was low. The primary's cascade bit stays level-sensitive. Primary request bit 2 follows the secondary output with one cycle of lag. A fully masked or empty request set keeps `int_out` low. A primary acknowledge outside auto mode sets the in-service bit of the winning line, and inside auto mode leaves the in-service bits alone.

Only the bench's scenarios can show the orderings that need history. These include priority after rotation, a level line coming back after end-of-interrupt while an edge line does not, preemption of an in-service line by a higher one, and the two-level vector returned through the cascade.

// File: rtl/irq_cascade_pkg.sv
// Shared widths, types and fixed constants for the cascaded controller pair.
// Assumes eight lines per controller and an eight-bit vector.
package irq_cascade_pkg;
    localparam int LINES   = 8;
    localparam int LW      = $clog2(LINES);
    localparam int VEC_W   = 8;
    localparam int VBASE_W = VEC_W - LW;

    typedef logic [LINES-1:0]   vec_t;
    typedef logic [LW-1:0]      line_t;
    typedef logic [VBASE_W-1:0] vbase_t;

    // Trigger-mode write/read masks: cleared bits are fixed edge-sensitive.
    localparam vec_t  PRI_TRIG_MASK = 8'hF8;
    localparam vec_t  SEC_TRIG_MASK = 8'hDE;
    // Primary line fed by the secondary's output.
    localparam line_t CASCADE_LINE  = 3'd2;
endpackage

// File: rtl/irq_rot_prio.sv
// Rotating priority resolver: finds the highest-priority set bit of req,
// where the rotation offset names the line of highest priority.
// Outputs the rank (0 = highest) of the winner; callers add rot back for
// the line number. Purely combinational.
module irq_rot_prio
    import irq_cascade_pkg::*;
(
    input  vec_t  req,
    input  line_t rot,
    output logic  found,
    output line_t rank
);
    vec_t rotated;

    // Rotate right by rot so that rank 0 holds line rot.
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_rot
            localparam line_t POS = line_t'(g);
            line_t src;
            assign src        = POS + rot;
            assign rotated[g] = req[src];
        end
    endgenerate

    // Lowest-rank set bit wins.
    always_comb begin
        found = 1'b0;
        rank  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (rotated[i]) begin
                found = 1'b1;
                rank  = line_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_trig_regs.sv
// Trigger-mode registers for both controllers. Writes pass through a fixed
// per-controller mask; the primary's cascade bit is always held level.
// Reads return the masked view, hiding the forced cascade bit.
module irq_trig_regs
    import irq_cascade_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic sel,
    input  vec_t wdata,
    output vec_t pri_trig,
    output vec_t sec_trig,
    output vec_t rdata
);
    localparam vec_t CASC_BIT = vec_t'(1) << CASCADE_LINE;

    vec_t pri_q, sec_q;

    // Masked storage of the trigger modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= CASC_BIT;
            sec_q <= '0;
        end else if (wr) begin
            if (sel) sec_q <= wdata & SEC_TRIG_MASK;
            else     pri_q <= (wdata & PRI_TRIG_MASK) | CASC_BIT;
        end
    end

    // Masked read-back of the selected controller.
    always_comb begin
        rdata = sel ? (sec_q & SEC_TRIG_MASK) : (pri_q & PRI_TRIG_MASK);
    end

    assign pri_trig = pri_q;
    assign sec_trig = sec_q;
endmodule

// File: rtl/irq_unit.sv
// One eight-line controller: request edge detection, request and
// in-service registers, rotation offset, arbitration and acknowledge.
// Assumes ack_take is raised only when int_o is high; the caller gates it.
module irq_unit
    import irq_cascade_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  vec_t  req_lvl,
    input  vec_t  trig,
    input  vec_t  imr,
    input  logic  aeoi,
    input  logic  rot_aeoi,
    input  logic  ack_take,
    input  logic  eoi_take,
    input  line_t eoi_line,
    output logic  int_o,
    output line_t win_line,
    output vec_t  irr_o,
    output vec_t  isr_o
);
    vec_t  req_q, irr_q, isr_q;
    line_t rot_q;
    vec_t  pend, rise, fall, ack_oh, eoi_oh, irr_nxt, isr_nxt;
    logic  p_found, s_found;
    line_t p_rank, s_rank;

    assign pend = irr_q & ~imr;

    irq_rot_prio u_pend (
        .req   (pend),
        .rot   (rot_q),
        .found (p_found),
        .rank  (p_rank)
    );

    irq_rot_prio u_serv (
        .req   (isr_q),
        .rot   (rot_q),
        .found (s_found),
        .rank  (s_rank)
    );

    // Output asserts when a pending line outranks every in-service line.
    always_comb begin
        int_o    = p_found && (!s_found || (p_rank < s_rank));
        win_line = p_rank + rot_q;
    end

    // One-hot decodes of the acknowledged and end-of-interrupt lines.
    always_comb begin
        ack_oh = '0;
        eoi_oh = '0;
        if (ack_take) ack_oh[win_line] = 1'b1;
        if (eoi_take) eoi_oh[eoi_line] = 1'b1;
    end

    // Next-state of requests and in-service bits.
    always_comb begin
        rise    = req_lvl & ~req_q;
        fall    = ~req_lvl & req_q;
        irr_nxt = ((irr_q & ~(ack_oh & ~trig)) | rise) & ~fall;
        isr_nxt = (isr_q | (aeoi ? '0 : ack_oh)) & ~eoi_oh;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            irr_q <= '0;
            isr_q <= '0;
            rot_q <= '0;
        end else begin
            req_q <= req_lvl;
            irr_q <= irr_nxt;
            isr_q <= isr_nxt;
            if (ack_take && aeoi && rot_aeoi) rot_q <= win_line + line_t'(1);
        end
    end

    assign irr_o = irr_q;
    assign isr_o = isr_q;
endmodule

// File: rtl/irq_cascade_pair.sv
// Top of the cascaded pair. The secondary's output replaces external
// input 2 on the primary. An accepted acknowledge resolves the primary and,
// on the cascade line, the secondary in the same cycle; the vector is
// registered. Programming arrives as plain configuration inputs.
module irq_cascade_pair
    import irq_cascade_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_in,
    input  logic [7:0]  m_imr,
    input  logic [7:0]  s_imr,
    input  logic [4:0]  m_vbase,
    input  logic [4:0]  s_vbase,
    input  logic        m_aeoi,
    input  logic        s_aeoi,
    input  logic        m_rot_aeoi,
    input  logic        s_rot_aeoi,
    input  logic        eoi_req,
    input  logic        eoi_sel,
    input  logic [2:0]  eoi_line,
    input  logic        tm_wr,
    input  logic        tm_sel,
    input  logic [7:0]  tm_wdata,
    output logic [7:0]  tm_rdata,
    output logic        int_out,
    input  logic        ack_req,
    output logic        ack_valid,
    output logic [7:0]  ack_vector
);
    localparam vec_t  CASC_BIT  = vec_t'(1) << CASCADE_LINE;
    localparam line_t SPUR_LINE = line_t'(LINES - 1);

    vec_t  m_trig, s_trig, m_req, m_irr, m_isr, s_irr, s_isr;
    logic  m_int, s_int, acc, casc, m_ack, s_ack;
    line_t m_line, s_line, s_pick;
    logic [VEC_W-1:0] vec_nxt;

    irq_trig_regs u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (tm_wr),
        .sel      (tm_sel),
        .wdata    (tm_wdata),
        .pri_trig (m_trig),
        .sec_trig (s_trig),
        .rdata    (tm_rdata)
    );

    // External line 2 is dropped; the secondary's output takes its place.
    always_comb begin
        m_req = (irq_in[LINES-1:0] & ~CASC_BIT) | (s_int ? CASC_BIT : '0);
    end

    // Acknowledge steering across the two levels.
    always_comb begin
        acc    = ack_req && m_int;
        m_ack  = acc;
        casc   = acc && (m_line == CASCADE_LINE);
        s_ack  = casc && s_int;
        s_pick = s_int ? s_line : SPUR_LINE;
        vec_nxt = casc ? {s_vbase, s_pick} : {m_vbase, m_line};
    end

    irq_unit u_pri (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_lvl  (m_req),
        .trig     (m_trig),
        .imr      (m_imr),
        .aeoi     (m_aeoi),
        .rot_aeoi (m_rot_aeoi),
        .ack_take (m_ack),
        .eoi_take (eoi_req && !eoi_sel),
        .eoi_line (eoi_line),
        .int_o    (m_int),
        .win_line (m_line),
        .irr_o    (m_irr),
        .isr_o    (m_isr)
    );

    irq_unit u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_lvl  (irq_in[2*LINES-1:LINES]),
        .trig     (s_trig),
        .imr      (s_imr),
        .aeoi     (s_aeoi),
        .rot_aeoi (s_rot_aeoi),
        .ack_take (s_ack),
        .eoi_take (eoi_req && eoi_sel),
        .eoi_line (eoi_line),
        .int_o    (s_int),
        .win_line (s_line),
        .irr_o    (s_irr),
        .isr_o    (s_isr)
    );

    // Registered acknowledge result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid <= acc;
            if (acc) ack_vector <= vec_nxt;
        end
    end

    assign int_out = m_int;
endmodule

// File: rtl/irq_cascade_pair_chk.sv
// Property checker for the cascaded pair, bound to the top module.
module irq_cascade_pair_chk
    import irq_cascade_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  ack_req,
    input logic  int_out,
    input logic  ack_valid,
    input logic  eoi_req,
    input logic  m_aeoi,
    input vec_t  m_imr,
    input vec_t  m_trig,
    input vec_t  m_irr,
    input vec_t  m_isr,
    input vec_t  s_irr,
    input vec_t  s_isr,
    input logic  s_int,
    input line_t m_line
);
    AST_ACK_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !int_out) |=> !ack_valid);                         // R9
    AST_VALID_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ($past(ack_req) && $past(int_out)));             // R4
    AST_CASCADE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        m_trig[CASCADE_LINE]);                                         // R2
    AST_CASCADE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (m_irr[CASCADE_LINE] == $past(s_int)));               // R7
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_irr & ~m_imr) == '0) |-> !int_out);                        // R10
    AST_ISR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && int_out && !m_aeoi && !eoi_req) |=> m_isr[$past(m_line)]); // R6
    AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && int_out && m_aeoi && !eoi_req) |=> $stable(m_isr)); // R8
    AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_irr == '0) && (s_isr == '0)) |-> !s_int);                  // R7
endmodule

bind irq_cascade_pair irq_cascade_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_req   (ack_req),
    .int_out   (int_out),
    .ack_valid (ack_valid),
    .eoi_req   (eoi_req),
    .m_aeoi    (m_aeoi),
    .m_imr     (m_imr),
    .m_trig    (m_trig),
    .m_irr     (m_irr),
    .m_isr     (m_isr),
    .s_irr     (s_irr),
    .s_isr     (s_isr),
    .s_int     (s_int),
    .m_line    (m_line)
);

// File: tb/irq_cascade_pair_tb.sv
// Scoreboard bench: the acknowledge driver queues expected results and a
// monitor compares them with the registered vector one cycle later.
module irq_cascade_pair_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [7:0]  m_imr = '0, s_imr = '0;
    logic [4:0]  m_vbase = 5'h04, s_vbase = 5'h05;
    logic        m_aeoi = 1'b0, s_aeoi = 1'b0, m_rot_aeoi = 1'b0, s_rot_aeoi = 1'b0;
    logic        eoi_req = 1'b0, eoi_sel = 1'b0;
    logic [2:0]  eoi_line = '0;
    logic        tm_wr = 1'b0, tm_sel = 1'b0;
    logic [7:0]  tm_wdata = '0;
    logic [7:0]  tm_rdata;
    logic        int_out, ack_req = 1'b0, ack_valid;
    logic [7:0]  ack_vector;

    int n_checks = 0;
    int n_fail   = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_pair u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .m_imr(m_imr), .s_imr(s_imr), .m_vbase(m_vbase), .s_vbase(s_vbase),
        .m_aeoi(m_aeoi), .s_aeoi(s_aeoi), .m_rot_aeoi(m_rot_aeoi), .s_rot_aeoi(s_rot_aeoi),
        .eoi_req(eoi_req), .eoi_sel(eoi_sel), .eoi_line(eoi_line),
        .tm_wr(tm_wr), .tm_sel(tm_sel), .tm_wdata(tm_wdata), .tm_rdata(tm_rdata),
        .int_out(int_out), .ack_req(ack_req), .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int idx, logic v);
        irq_in[idx] = v;
        @(negedge clk);
    endtask

    // Driver: queue expectation {valid, vector}, pulse ack_req one cycle.
    task automatic do_ack(logic v, logic [7:0] vec, string tag);
        exp_q.push_back({v, vec});
        tag_q.push_back(tag);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic do_eoi(logic sel, logic [2:0] line);
        eoi_sel = sel; eoi_line = line; eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    task automatic tm_write(logic sel, logic [7:0] d);
        tm_sel = sel; tm_wdata = d; tm_wr = 1'b1;
        @(negedge clk);
        tm_wr = 1'b0;
    endtask

    // Monitor: after an edge that sampled ack_req, compare at the next negedge.
    initial begin
        forever begin
            @(posedge clk);
            if (ack_req === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("scoreboard empty", 8'h01, 8'h00);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " ack_valid"}, {7'b0, ack_valid}, {7'b0, e[8]});
                    if (e[8]) check({t, " ack_vector"}, ack_vector, e[7:0]);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 int_out", {7'b0, int_out}, 8'h00);
        check("R1 ack_valid", {7'b0, ack_valid}, 8'h00);
        tm_sel = 1'b0; tick(1);
        check("R1 primary trig read", tm_rdata, 8'h00);
        tm_sel = 1'b1; tick(1);
        check("R1 secondary trig read", tm_rdata, 8'h00);

        // R9 idle acknowledge
        do_ack(1'b0, 8'h00, "R9 idle ack");

        // R2 trigger masks
        tm_write(1'b0, 8'hFF);
        check("R2 primary mask", tm_rdata, 8'hF8);
        tm_write(1'b1, 8'hFF);
        check("R2 secondary mask", tm_rdata, 8'hDE);
        tm_write(1'b1, 8'h00);
        check("R2 secondary clear", tm_rdata, 8'h00);
        tm_write(1'b0, 8'h08);
        check("R2 primary line3 level", tm_rdata, 8'h08);

        // R3 external line 2 ignored
        set_line(2, 1'b1);
        tick(2);
        check("R3 line2 ignored", {7'b0, int_out}, 8'h00);
        set_line(2, 1'b0);

        // R4/R5/R6 fixed priority, level versus edge, in-service blocking
        irq_in[3] = 1'b1; irq_in[5] = 1'b1;
        tick(1);
        check("R3 rise sets request", {7'b0, int_out}, 8'h01);
        do_ack(1'b1, 8'h23, "R4 lowest line wins");
        check("R6 in-service blocks", {7'b0, int_out}, 8'h00);
        do_eoi(1'b0, 3'd3);
        check("R5 level line re-requests", {7'b0, int_out}, 8'h01);
        do_ack(1'b1, 8'h23, "R5 level line again");
        do_eoi(1'b0, 3'd3);
        set_line(3, 1'b0);
        check("R3 fall then line5 pending", {7'b0, int_out}, 8'h01);
        do_ack(1'b1, 8'h25, "R4 line5 vector");
        do_eoi(1'b0, 3'd5);
        check("R5 edge request cleared", {7'b0, int_out}, 8'h00);
        set_line(5, 1'b0);

        // R6 preemption
        set_line(6, 1'b1);
        do_ack(1'b1, 8'h26, "R6 line6");
        check("R6 line6 in service", {7'b0, int_out}, 8'h00);
        set_line(1, 1'b1);
        check("R6 higher preempts", {7'b0, int_out}, 8'h01);
        do_ack(1'b1, 8'h21, "R6 nested line1");
        do_eoi(1'b0, 3'd1);
        do_eoi(1'b0, 3'd6);
        check("R6 all serviced", {7'b0, int_out}, 8'h00);
        irq_in[1] = 1'b0; irq_in[6] = 1'b0;
        tick(1);

        // R10 mask
        m_imr = 8'h10;
        set_line(4, 1'b1);
        tick(1);
        check("R10 masked quiet", {7'b0, int_out}, 8'h00);
        m_imr = 8'h00;
        tick(1);
        check("R10 unmask raises", {7'b0, int_out}, 8'h01);
        do_ack(1'b1, 8'h24, "R10 line4");
        do_eoi(1'b0, 3'd4);
        set_line(4, 1'b0);

        // R3 falling edge clears before acknowledge
        set_line(7, 1'b1);
        check("R3 line7 raised", {7'b0, int_out}, 8'h01);
        set_line(7, 1'b0);
        check("R3 fall clears", {7'b0, int_out}, 8'h00);

        // R7 cascade
        set_line(12, 1'b1);
        tick(1);
        check("R7 cascade raises output", {7'b0, int_out}, 8'h01);
        do_ack(1'b1, 8'h2C, "R7 secondary vector");
        tick(1);
        check("R7 both in service", {7'b0, int_out}, 8'h00);
        do_eoi(1'b1, 3'd4);
        do_eoi(1'b0, 3'd2);
        tick(2);
        check("R7 cascade drained", {7'b0, int_out}, 8'h00);
        set_line(12, 1'b0);

        // R8 auto end-of-interrupt with rotation
        m_aeoi = 1'b1; m_rot_aeoi = 1'b1;
        irq_in[1] = 1'b1; irq_in[4] = 1'b1;
        tick(1);
        do_ack(1'b1, 8'h21, "R8 first line1");
        check("R8 no in-service", {7'b0, int_out}, 8'h01);
        set_line(1, 1'b0);
        set_line(1, 1'b1);
        do_ack(1'b1, 8'h24, "R8 rotated priority");
        do_ack(1'b1, 8'h21, "R8 line1 last");
        check("R8 drained", {7'b0, int_out}, 8'h00);
        irq_in = '0;
        tick(2);

        report();
        $finish;
    end
endmodule